// File: doc/BRIEF.md
# Key-Sealed Pin Function Register

This block holds a pin-function control word behind a two-key handshake on a simple register bus. The bus has an address, write data, a write strobe and a combinational read port. The protected word changes only after three bus writes arrive in a fixed order. The first is an opening key. The second is the new value. The third is a closing key. The new value is parked in a shadow register and reaches the live word only when the closing key arrives. Any other ordering throws the parked value away, leaves the live word as it was and raises a sticky fault flag.

A second register is not protected. It is written directly and holds the routing-enable bits for a group of four port pins. The block combines the two registers into one signal. That signal requests the serial peripheral function on the group when all four enable bits are set and the steering bit of the protected word is clear.

The register map is: address 0 is the plain enable register, address 1 is the opening key, address 2 is the protected word, address 3 is the closing key, and address 4 is the fault flag in bit 0.

Top module: `keylock_cfg`

## Requirements
- R1: While reset is applied, the outputs are: protected word 0x02, plain register 0x00, fault flag 0, route signal 0.
- R2: The protected word takes the data written to address 2 when that write comes in this exact sequence: first 0x07 written to address 1, then the write to address 2, then 0x13 written to address 3. The new value appears in the cycle after the write of 0x13. Idle bus cycles between the three writes do not break the sequence.
- R3: A write to address 2 that is not directly preceded by a correct opening key leaves the protected word unchanged and sets the fault flag.
- R4: After a pending write to address 2, the next write must be 0x13 to address 3. Any other next write discards the pending value, leaves the protected word unchanged and sets the fault flag.
- R5: Any write between the opening key and the write to address 2 breaks the sequence and sets the fault flag. A later write to address 2 then has no effect.
- R6: With no sequence in progress, two kinds of write set the fault flag and change nothing else: a value other than 0x07 written to address 1, and any write to address 3.
- R7: The fault flag stays set until a write to address 4 with bit 0 equal to 1. Writing 0 to bit 0 does not clear it. If the same write both breaks a sequence and clears the flag, the flag stays set.
- R8: Reading address 2 always returns the live protected word. It never returns the pending value.
- R9: Addresses 1 and 3 read as zero. Address 4 reads the fault flag in bit 0 with all other bits zero. Address 0 reads the plain register. Unmapped addresses read zero.
- R10: A write to address 0 updates the plain register in the next cycle, with no key needed. Any write, including one to address 0, breaks an open sequence. Cycles with the write strobe low change no state.
- R11: The route output is 1 exactly when bits 3 to 0 of the plain register are all 1 and bit 1 of the protected word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Release is synchronised inside the block. |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe. One write per cycle while high. |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| prot_bits | output | 8 | Live protected pin-function word |
| plain_bits | output | 8 | Plain routing-enable register |
| seq_fault | output | 1 | Sticky fault flag for a broken sequence |
| serial_route | output | 1 | Request for the serial peripheral function on the pin group |

## Verification
Four properties are checked on every cycle:
- the protected word changes only one cycle after a correct closing key;
- a pending value that meets anything but the closing key leaves the word stable and raises the fault;
- the fault flag rises only after a bus write and falls only after a write of 1 to its bit;
- an idle bus never moves the sequence state.

Some behaviours can only be shown by the bench's scenarios, which track a behavioural model cycle by cycle. These are:
- the correct ordering with idle gaps;
- each way of breaking the sequence;
- the set-beats-clear case on the fault flag;
- reads that return the live word rather than the pending one;
- the route output across combinations of the two registers.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_PEND  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic open_addr;
    logic open_ok;
    logic prot_addr;
    logic seal_addr;
    logic seal_ok;
  } seq_dec_t;
endpackage

// File: rtl/keylock_seq.sv
module keylock_seq
  import keylock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  seq_dec_t   dec,
  output logic       capture_o,
  output logic       commit_o,
  output logic       fault_o,
  output seq_state_e state_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    capture_o = 1'b0;
    commit_o  = 1'b0;
    fault_o   = 1'b0;
    if (wr_en) begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (dec.open_addr) begin
            if (dec.open_ok) state_d = SEQ_ARMED;
            else             fault_o = 1'b1;
          end else if (dec.prot_addr || dec.seal_addr) begin
            fault_o = 1'b1;
          end
        end
        SEQ_ARMED: begin
          if (dec.prot_addr) begin
            capture_o = 1'b1;
            state_d   = SEQ_PEND;
          end else begin
            fault_o = 1'b1;
            state_d = SEQ_IDLE;
          end
        end
        SEQ_PEND: begin
          if (dec.seal_ok) commit_o = 1'b1;
          else             fault_o  = 1'b1;
          state_d = SEQ_IDLE;
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  AST_IDLE_BUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(state_q)); // R10
endmodule

// File: rtl/keylock_store.sv
module keylock_store #(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] PROT_RST  = 'h02,
  parameter logic [DATA_W-1:0] PLAIN_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              capture,
  input  logic              commit,
  input  logic              fault,
  input  logic              plain_we,
  input  logic              fault_clr,
  output logic [DATA_W-1:0] live_o,
  output logic [DATA_W-1:0] plain_o,
  output logic              fault_q_o
);
  logic [DATA_W-1:0] shadow_q, live_q, plain_q;
  logic              fault_q, fault_d;

  assign fault_d = fault ? 1'b1 : (fault_clr ? 1'b0 : fault_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shadow_q <= '0;
    else if (capture) shadow_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      live_q <= PROT_RST;
    else if (commit) live_q <= shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        plain_q <= PLAIN_RST;
    else if (plain_we) plain_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_d;
  end

  assign live_o    = live_q;
  assign plain_o   = plain_q;
  assign fault_q_o = fault_q;

  AST_LIVE_MOVES_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(live_q) |-> $past(commit)); // R2
endmodule

// File: rtl/keylock_rdmux.sv
module keylock_rdmux #(
  parameter int                ADDR_W  = 4,
  parameter int                DATA_W  = 8,
  parameter logic [ADDR_W-1:0] A_PLAIN = 'd0,
  parameter logic [ADDR_W-1:0] A_PROT  = 'd2,
  parameter logic [ADDR_W-1:0] A_ERR   = 'd4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] live,
  input  logic [DATA_W-1:0] plain,
  input  logic              fault,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (addr == A_PROT)       rdata = live;
    else if (addr == A_PLAIN) rdata = plain;
    else if (addr == A_ERR)   rdata = {{(DATA_W-1){1'b0}}, fault};
  end
endmodule

// File: rtl/keylock_cfg.sv
module keylock_cfg
  import keylock_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter int                DATA_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] A_PLAIN     = 'd0,
  parameter logic [ADDR_W-1:0] A_OPEN      = 'd1,
  parameter logic [ADDR_W-1:0] A_PROT      = 'd2,
  parameter logic [ADDR_W-1:0] A_SEAL      = 'd3,
  parameter logic [ADDR_W-1:0] A_ERR       = 'd4,
  parameter logic [DATA_W-1:0] KEY_OPEN    = 'h07,
  parameter logic [DATA_W-1:0] KEY_SEAL    = 'h13,
  parameter logic [DATA_W-1:0] PROT_RST    = 'h02,
  parameter logic [DATA_W-1:0] PLAIN_RST   = '0,
  parameter int                GROUP_PINS  = 4,
  parameter int                STEER_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] prot_bits,
  output logic [DATA_W-1:0] plain_bits,
  output logic              seq_fault,
  output logic              serial_route
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] rst_sync_q;
  logic              rst_int_n;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= {rst_sync_q[SYNC_MSB-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_int_n = rst_sync_q[SYNC_MSB];

  seq_dec_t   dec;
  logic       capture, commit, fault;
  seq_state_e seq_state;
  logic       plain_we, fault_clr;

  always_comb begin
    dec.open_addr = (bus_addr == A_OPEN);
    dec.open_ok   = (bus_addr == A_OPEN) && (bus_wdata == KEY_OPEN);
    dec.prot_addr = (bus_addr == A_PROT);
    dec.seal_addr = (bus_addr == A_SEAL);
    dec.seal_ok   = (bus_addr == A_SEAL) && (bus_wdata == KEY_SEAL);
  end

  assign plain_we  = bus_we && (bus_addr == A_PLAIN);
  assign fault_clr = bus_we && (bus_addr == A_ERR) && bus_wdata[0];

  keylock_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (bus_we),
    .dec       (dec),
    .capture_o (capture),
    .commit_o  (commit),
    .fault_o   (fault),
    .state_o   (seq_state)
  );

  keylock_store #(
    .DATA_W    (DATA_W),
    .PROT_RST  (PROT_RST),
    .PLAIN_RST (PLAIN_RST)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wdata     (bus_wdata),
    .capture   (capture),
    .commit    (commit),
    .fault     (fault),
    .plain_we  (plain_we),
    .fault_clr (fault_clr),
    .live_o    (prot_bits),
    .plain_o   (plain_bits),
    .fault_q_o (seq_fault)
  );

  keylock_rdmux #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .A_PLAIN (A_PLAIN),
    .A_PROT  (A_PROT),
    .A_ERR   (A_ERR)
  ) u_rdmux (
    .addr  (bus_addr),
    .live  (prot_bits),
    .plain (plain_bits),
    .fault (seq_fault),
    .rdata (bus_rdata)
  );

  assign serial_route = (&plain_bits[GROUP_PINS-1:0]) && !prot_bits[STEER_BIT];

  AST_SEAL_BEFORE_CHANGE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(prot_bits) |-> $past(bus_we && bus_addr == A_SEAL && bus_wdata == KEY_SEAL)); // R2

  AST_BROKEN_PEND_DROPS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (seq_state == SEQ_PEND && bus_we && !(bus_addr == A_SEAL && bus_wdata == KEY_SEAL))
      |=> ($stable(prot_bits) && seq_fault)); // R4

  AST_FAULT_RISE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(seq_fault) |-> $past(bus_we)); // R3

  AST_FAULT_FALL_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(seq_fault) |-> $past(bus_we && bus_addr == A_ERR && bus_wdata[0])); // R7
endmodule

// File: tb/keylock_cfg_bench.sv
`timescale 1ns/1ps
module keylock_cfg_bench;
  logic       clk;
  logic       rst_n;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_we;
  logic [7:0] bus_rdata, prot_bits, plain_bits;
  logic       seq_fault, serial_route;

  keylock_cfg u_keylock_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_we       (bus_we),
    .bus_rdata    (bus_rdata),
    .prot_bits    (prot_bits),
    .plain_bits   (plain_bits),
    .seq_fault    (seq_fault),
    .serial_route (serial_route)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cycles = 0;
  string cur_req = "R1";

  // behavioural reference
  int   rel = 0;
  int   m_state = 0;
  logic [7:0] m_live = 8'h02, m_shadow = 8'h00, m_plain = 8'h00;
  logic m_err = 1'b0;

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", cur_req, what, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    logic flt;
    logic [7:0] exp_rd;
    #1;
    cycles++;
    flt = 1'b0;
    if (!rst_n) begin
      rel = 0; m_state = 0; m_live = 8'h02; m_shadow = 8'h00; m_plain = 8'h00; m_err = 1'b0;
    end else begin
      if (rel >= 2 && bus_we) begin
        case (m_state)
          0: begin
            if (bus_addr == 4'd1) begin
              if (bus_wdata == 8'h07) m_state = 1; else flt = 1'b1;
            end else if (bus_addr == 4'd2 || bus_addr == 4'd3) flt = 1'b1;
          end
          1: begin
            if (bus_addr == 4'd2) begin m_shadow = bus_wdata; m_state = 2; end
            else begin flt = 1'b1; m_state = 0; end
          end
          default: begin
            if (bus_addr == 4'd3 && bus_wdata == 8'h13) m_live = m_shadow;
            else flt = 1'b1;
            m_state = 0;
          end
        endcase
        if (bus_addr == 4'd0) m_plain = bus_wdata;
        if (flt) m_err = 1'b1;
        else if (bus_addr == 4'd4 && bus_wdata[0]) m_err = 1'b0;
      end
      if (rel < 2) rel++;
    end
    case (bus_addr)
      4'd0:    exp_rd = m_plain;
      4'd2:    exp_rd = m_live;
      4'd4:    exp_rd = {7'd0, m_err};
      default: exp_rd = 8'h00;
    endcase
    chk("prot_bits", prot_bits, m_live);
    chk("plain_bits", plain_bits, m_plain);
    chk("seq_fault", {7'd0, seq_fault}, {7'd0, m_err});
    chk("serial_route", {7'd0, serial_route}, {7'd0, (&m_plain[3:0]) & ~m_live[1]});
    chk("bus_rdata", bus_rdata, exp_rd);
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(input logic [3:0] a);
    @(negedge clk); bus_we = 1'b0; bus_addr = a; bus_wdata = 8'h00;
  endtask

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 4'd2; bus_wdata = 8'h00;
    cur_req = "R1";
    repeat (4) idle(4'd2);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) idle(4'd2);

    cur_req = "R2"; // clean sequence, steering bit cleared
    wr(4'd1, 8'h07); wr(4'd2, 8'hA5); wr(4'd3, 8'h13); idle(4'd2); idle(4'd2);
    cur_req = "R2_gaps"; // idle gaps between the writes
    wr(4'd1, 8'h07); idle(4'd2); wr(4'd2, 8'h3C); idle(4'd2); idle(4'd2);
    wr(4'd3, 8'h13); idle(4'd2);

    cur_req = "R3"; // data write with no opening key
    wr(4'd2, 8'h11); idle(4'd2); idle(4'd4);
    cur_req = "R7"; // clear with 0 does nothing, clear with 1 works
    wr(4'd4, 8'h00); idle(4'd4); wr(4'd4, 8'h01); idle(4'd4);

    cur_req = "R4"; // wrong closing key value; R8 read of address 2 while pending
    wr(4'd1, 8'h07); wr(4'd2, 8'hF0); idle(4'd2); idle(4'd2); wr(4'd3, 8'h12); idle(4'd2);
    wr(4'd4, 8'h01);
    cur_req = "R4_other"; // plain write in place of the closing key
    wr(4'd1, 8'h07); wr(4'd2, 8'h00); wr(4'd0, 8'h0F); idle(4'd2);
    wr(4'd3, 8'h13); idle(4'd2); wr(4'd4, 8'h01);

    cur_req = "R5"; // interloper between opening key and data
    wr(4'd1, 8'h07); wr(4'd0, 8'h03); wr(4'd2, 8'h00); wr(4'd3, 8'h13); idle(4'd2);
    wr(4'd4, 8'h01);

    cur_req = "R6"; // wrong opening key, stray closing key
    wr(4'd1, 8'h06); idle(4'd1); wr(4'd4, 8'h01);
    wr(4'd3, 8'h13); idle(4'd3);
    cur_req = "R7_setwins"; // clear attempt that itself breaks an armed sequence
    wr(4'd4, 8'h01); wr(4'd1, 8'h07); wr(4'd4, 8'h01); idle(4'd4); wr(4'd4, 8'h01);

    cur_req = "R11"; // route follows plain group and steering bit
    wr(4'd0, 8'h0F); idle(4'd0);
    wr(4'd1, 8'h07); wr(4'd2, 8'h00); wr(4'd3, 8'h13); idle(4'd2);
    wr(4'd0, 8'h07); idle(4'd0); wr(4'd0, 8'hFF); idle(4'd0);

    cur_req = "R9"; // read map
    idle(4'd1); idle(4'd3); idle(4'd4); idle(4'd0); idle(4'd7); idle(4'd15);
    cur_req = "R10"; // idle strobe with key values on the bus changes nothing
    @(negedge clk); bus_we = 1'b0; bus_addr = 4'd1; bus_wdata = 8'h07;
    @(negedge clk); bus_addr = 4'd2; bus_wdata = 8'h99;
    @(negedge clk); bus_addr = 4'd3; bus_wdata = 8'h13;
    idle(4'd2); idle(4'd2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #40000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule